// File: doc/BRIEF.md
# Frequency Synthesiser Loop Digital Core

This block holds the digital part of a phase-locked frequency synthesiser. A reference clock, given as one enable pulse per reference period, is divided by a fixed ratio to give the comparison tick. An oscillator clock that has already been divided by eight outside the block is also given as an enable. It is divided by a 15-bit ratio that is shifted in serially and then committed. A two-flop phase/frequency detector compares the two ticks and gives up/down pump requests. A lock detector watches how wide those requests are and raises a flag once the loop has settled.

A small set of control inputs shapes the outputs that go to the analog loop. One selects the pump current level. One silences both pump requests. One switches off the varactor drive amplifier. One test input places the comparison tick and the divided oscillator tick on two of the five port outputs. The tuned frequency is the ratio times eight times the comparison frequency. With a 4 MHz reference and the default divide-by-512, the comparison frequency is 7.8125 kHz.

Top module: `pll_synth_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lock_flag`, `pump_up` and `pump_dn` go to 0. The committed and active ratios clear to zero.
- R2: The comparison tick is a one-cycle pulse in the cycle after every REF_DIV-th clock with `ref_en` high.
- R3: The divided oscillator tick is a one-cycle pulse after every N-th clock with `osc_en` high, where N is the active 15-bit ratio. N of 0 or 1 divides by one.
- R4: Each clock with `ratio_shift` high shifts `ratio_sdat` into a 15-bit word, most significant bit first. `ratio_commit` copies that word to the pending ratio. Shifting without a commit has no effect on the division.
- R5: A pending ratio becomes active only at the terminal count of the cycle in progress. The cycle running when the commit happens keeps its old length.
- R6: The detector sets up on a comparison tick and down on a divider tick, and clears both once both are set. Up and down are never high together.
- R7: With `pump_off` high, `pump_up` and `pump_dn` are both 0.
- R8: `pump_hi` follows `cp_hi`, where 1 selects the high current. `drive_en` is the inverse of `drive_off`.
- R9: `lock_flag` rises at a comparison tick that closes LOCK_COUNT periods in a row in which no detector pulse lasted LOCK_WIN cycles. It falls in the cycle after any pulse reaches LOCK_WIN cycles.
- R10: `port_on` bits 0 to 4 follow `port_req`. When `test_route` is high, bit 2 shows the comparison tick and bit 4 shows the divided oscillator tick instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One pulse per reference period |
| osc_en | input | 1 | One pulse per prescaled oscillator period |
| ratio_sdat | input | 1 | Serial ratio data bit |
| ratio_shift | input | 1 | Shift ratio_sdat into the word |
| ratio_commit | input | 1 | Copy the shifted word to the pending ratio |
| cp_hi | input | 1 | 1 selects the high pump current |
| pump_off | input | 1 | 1 silences both pump requests |
| drive_off | input | 1 | 1 switches off the varactor drive |
| test_route | input | 1 | 1 routes the ticks to ports 2 and 4 |
| port_req | input | 5 | Requested port states (1 = sink on) |
| pump_up | output | 1 | Pump up request |
| pump_dn | output | 1 | Pump down request |
| pump_hi | output | 1 | Pump current select |
| drive_en | output | 1 | Varactor drive enable |
| port_on | output | 5 | Port states |
| lock_flag | output | 1 | Loop lock status |

## Verification
The bench builds the block with REF_DIV=8, LOCK_WIN=3 and LOCK_COUNT=4, and leaves RATIO_W at 15. A comparison period then lasts eight clocks, so an aligned loop locks after about forty cycles. A ratio of nine drifts by one clock per period, which breaks lock within three periods and lets it settle again later. The small periods also make the adoption of a new ratio at the terminal count, divide-by-one and the test routing visible in a few dozen cycles. A random phase with irregular enables then checks every output against a reference model in every cycle.

// File: rtl/pll_synth_pkg.sv
// Shared definitions for the synthesiser loop core.
// Assumes five port outputs, two of which can carry the test ticks.
package pll_synth_pkg;
    localparam int PORT_N     = 5;
    localparam int PORT_FCOMP = 2;
    localparam int PORT_FDIV  = 4;

    typedef struct packed {
        logic cp_hi;
        logic pump_off;
        logic drive_off;
        logic test_route;
    } synth_ctrl_t;
endpackage

// File: rtl/synth_ref_div.sv
// Fixed reference divider: one registered tick per REF_DIV reference enables.
// Assumes REF_DIV >= 1 and ref_en synchronous to clk.
module synth_ref_div #(
    parameter int REF_DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    output logic comp_tick
);
    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count reference enables and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            comp_tick <= 1'b0;
        end else begin
            comp_tick <= ref_en && (cnt == LAST);
            if (ref_en) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_prog_div.sv
// Programmable divider with a serial loader. The word is shifted in MSB first,
// committed to a pending ratio, and adopted only at the terminal count.
// Assumes ratios 0 and 1 both mean divide by one.
module synth_prog_div #(
    parameter int RATIO_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_en,
    input  logic               ratio_sdat,
    input  logic               ratio_shift,
    input  logic               ratio_commit,
    output logic               div_tick,
    output logic [RATIO_W-1:0] active_ratio
);
    logic [RATIO_W-1:0] shift_word;
    logic [RATIO_W-1:0] pending;
    logic [RATIO_W-1:0] cnt;
    logic               term;

    // Terminal count of the cycle in progress.
    always_comb begin
        term = (active_ratio <= RATIO_W'(1)) || (cnt == active_ratio - RATIO_W'(1));
    end

    // Serial load and commit to the pending ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_word <= '0;
            pending    <= '0;
        end else begin
            if (ratio_shift)  shift_word <= {shift_word[RATIO_W-2:0], ratio_sdat};
            if (ratio_commit) pending    <= shift_word;
        end
    end

    // Division counter; swaps the ratio only at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt          <= '0;
            active_ratio <= '0;
            div_tick     <= 1'b0;
        end else begin
            div_tick <= osc_en && term;
            if (osc_en) begin
                if (term) begin
                    cnt          <= '0;
                    active_ratio <= pending;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/synth_pfd.sv
// Two-flop phase/frequency detector: the comparison tick sets up and the divider
// tick sets down; both clear once both would be set.
module synth_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up,
    output logic dn
);
    logic up_set, dn_set;

    // Candidate states before the both-set reset.
    always_comb begin
        up_set = up | ref_tick;
        dn_set = dn | fb_tick;
    end

    // Update the detector flops with the mutual clear.
    always_ff @(posedge clk) begin
        if (!rst_n || (up_set && dn_set)) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_set;
            dn <= dn_set;
        end
    end
endmodule

// File: rtl/synth_lock_det.sv
// Lock detector: counts clean comparison periods and clears at once on a
// detector pulse reaching LOCK_WIN cycles. Assumes LOCK_WIN, LOCK_COUNT >= 1.
module synth_lock_det #(
    parameter int LOCK_WIN   = 8,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_tick,
    input  logic up,
    input  logic dn,
    output logic locked
);
    localparam int WW = $clog2(LOCK_WIN + 1);
    localparam int GW = $clog2(LOCK_COUNT + 1);

    logic [WW-1:0] width;
    logic [GW-1:0] good;
    logic          seen_wide;
    logic          active, wide;

    // A pulse counts as wide once it has lasted LOCK_WIN cycles.
    always_comb begin
        active = up | dn;
        wide   = active && (width >= WW'(LOCK_WIN - 1));
    end

    // Measure the running width of the detector pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) width <= '0;
        else if (width != WW'(LOCK_WIN)) width <= width + 1'b1;
    end

    // Track clean periods and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good      <= '0;
            seen_wide <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (comp_tick) begin
                seen_wide <= 1'b0;
                if (seen_wide || wide)           good <= '0;
                else if (good != GW'(LOCK_COUNT)) good <= good + 1'b1;
            end else if (wide) begin
                seen_wide <= 1'b1;
            end
            if (wide) locked <= 1'b0;
            else if (comp_tick && !seen_wide && (good >= GW'(LOCK_COUNT - 1))) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/pll_synth_core.sv
// Digital core of a frequency-synthesiser loop: reference divider, programmable
// divider, phase/frequency detector, lock detector, pump gating and test routing.
// Assumes ref_en and osc_en are clock enables synchronous to clk.
module pll_synth_core
    import pll_synth_pkg::*;
#(
    parameter int REF_DIV    = 512,
    parameter int RATIO_W    = 15,
    parameter int LOCK_WIN   = 8,
    parameter int LOCK_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              osc_en,
    input  logic              ratio_sdat,
    input  logic              ratio_shift,
    input  logic              ratio_commit,
    input  logic              cp_hi,
    input  logic              pump_off,
    input  logic              drive_off,
    input  logic              test_route,
    input  logic [PORT_N-1:0] port_req,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              pump_hi,
    output logic              drive_en,
    output logic [PORT_N-1:0] port_on,
    output logic              lock_flag
);
    synth_ctrl_t        ctrl;
    logic               comp_tick, div_tick;
    logic               det_up, det_dn;
    logic [RATIO_W-1:0] active_ratio;

    // Group the control bits.
    always_comb begin
        ctrl = '{cp_hi: cp_hi, pump_off: pump_off, drive_off: drive_off, test_route: test_route};
    end

    synth_ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .comp_tick(comp_tick)
    );

    synth_prog_div #(.RATIO_W(RATIO_W)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ratio_sdat(ratio_sdat),
        .ratio_shift(ratio_shift), .ratio_commit(ratio_commit),
        .div_tick(div_tick), .active_ratio(active_ratio)
    );

    synth_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_tick(comp_tick), .fb_tick(div_tick),
        .up(det_up), .dn(det_dn)
    );

    synth_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk(clk), .rst_n(rst_n), .comp_tick(comp_tick), .up(det_up), .dn(det_dn),
        .locked(lock_flag)
    );

    // Gate the pump requests and drive the analog controls.
    always_comb begin
        pump_up  = det_up & ~ctrl.pump_off;
        pump_dn  = det_dn & ~ctrl.pump_off;
        pump_hi  = ctrl.cp_hi;
        drive_en = ~ctrl.drive_off;
    end

    // Port outputs, with the two ticks substituted in test mode.
    for (genvar i = 0; i < PORT_N; i++) begin : g_port
        if (i == PORT_FCOMP) begin : g_fcomp
            assign port_on[i] = ctrl.test_route ? comp_tick : port_req[i];
        end else if (i == PORT_FDIV) begin : g_fdiv
            assign port_on[i] = ctrl.test_route ? div_tick : port_req[i];
        end else begin : g_plain
            assign port_on[i] = port_req[i];
        end
    end
endmodule

// File: rtl/pll_synth_core_chk.sv
// Property checker for pll_synth_core, attached by bind below.
module pll_synth_core_chk #(
    parameter int REF_DIV  = 512,
    parameter int RATIO_W  = 15,
    parameter int LOCK_WIN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               comp_tick,
    input logic               div_tick,
    input logic               det_up,
    input logic               det_dn,
    input logic [RATIO_W-1:0] active_ratio,
    input logic               lock_flag,
    input logic               pump_off,
    input logic               pump_up,
    input logic               pump_dn
);
    localparam int RW = $clog2(LOCK_WIN + 1);
    logic [RW-1:0] run;

    // Independent measure of the detector pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n || !(det_up || det_dn)) run <= '0;
        else if (run != RW'(LOCK_WIN)) run <= run + 1'b1;
    end

    // R6
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(det_up && det_dn));
    // R7
    pump_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_off |-> (!pump_up && !pump_dn));
    // R5
    ratio_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_ratio) |-> div_tick);
    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(comp_tick));
    // R9
    wide_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((det_up || det_dn) && (run >= RW'(LOCK_WIN - 1))) |=> !lock_flag);
    // R2
    comp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_tick && (REF_DIV > 1)) |=> !comp_tick);
endmodule

bind pll_synth_core pll_synth_core_chk #(
    .REF_DIV(REF_DIV), .RATIO_W(RATIO_W), .LOCK_WIN(LOCK_WIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .comp_tick(comp_tick), .div_tick(div_tick),
    .det_up(det_up), .det_dn(det_dn), .active_ratio(active_ratio),
    .lock_flag(lock_flag), .pump_off(pump_off), .pump_up(pump_up), .pump_dn(pump_dn)
);

// File: tb/tb_pll_synth_core.sv
// Bench for pll_synth_core: a behavioural model is compared every clock,
// plus directed checks per requirement.
module tb_pll_synth_core;
    localparam int CLK_PERIOD = 10;
    localparam int REFD = 8;
    localparam int LW   = 3;
    localparam int LC   = 4;
    localparam int RMASK = (1 << 15) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_en = 0, osc_en = 0, ratio_sdat = 0, ratio_shift = 0, ratio_commit = 0;
    logic cp_hi = 0, pump_off = 0, drive_off = 0, test_route = 0;
    logic [4:0] port_req = '0;
    logic pump_up, pump_dn, pump_hi, drive_en, lock_flag;
    logic [4:0] port_on;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_synth_core #(.REF_DIV(REFD), .RATIO_W(15), .LOCK_WIN(LW), .LOCK_COUNT(LC)) dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .osc_en(osc_en),
        .ratio_sdat(ratio_sdat), .ratio_shift(ratio_shift), .ratio_commit(ratio_commit),
        .cp_hi(cp_hi), .pump_off(pump_off), .drive_off(drive_off), .test_route(test_route),
        .port_req(port_req), .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi),
        .drive_en(drive_en), .port_on(port_on), .lock_flag(lock_flag)
    );

    // Behavioural reference model state.
    int m_rcnt, m_sh, m_pend, m_act, m_cnt, m_w, m_good;
    bit m_ctick, m_dtick, m_up, m_dn, m_seen, m_lock;

    always @(posedge clk) begin
        int n_rcnt, n_sh, n_pend, n_act, n_cnt, n_w, n_good;
        bit n_ctick, n_dtick, n_up, n_dn, n_seen, n_lock, term, su, sd, act, wide;
        if (!rst_n) begin
            m_rcnt = 0; m_sh = 0; m_pend = 0; m_act = 0; m_cnt = 0; m_w = 0; m_good = 0;
            m_ctick = 0; m_dtick = 0; m_up = 0; m_dn = 0; m_seen = 0; m_lock = 0;
        end else begin
            n_ctick = ref_en && (m_rcnt == REFD - 1);
            n_rcnt  = ref_en ? ((m_rcnt == REFD - 1) ? 0 : m_rcnt + 1) : m_rcnt;
            n_sh    = ratio_shift ? (((m_sh << 1) | ratio_sdat) & RMASK) : m_sh;
            n_pend  = ratio_commit ? m_sh : m_pend;
            term    = (m_act <= 1) || (m_cnt == m_act - 1);
            n_dtick = osc_en && term;
            n_cnt = m_cnt; n_act = m_act;
            if (osc_en) begin
                if (term) begin n_cnt = 0; n_act = m_pend; end
                else n_cnt = m_cnt + 1;
            end
            su = m_up || m_ctick;
            sd = m_dn || m_dtick;
            if (su && sd) begin n_up = 0; n_dn = 0; end
            else begin n_up = su; n_dn = sd; end
            act  = m_up || m_dn;
            wide = act && (m_w >= LW - 1);
            n_w  = act ? ((m_w + 1 > LW) ? LW : m_w + 1) : 0;
            n_good = m_good; n_seen = m_seen; n_lock = m_lock;
            if (m_ctick) begin
                n_seen = 0;
                if (m_seen || wide) n_good = 0;
                else if (m_good < LC) n_good = m_good + 1;
            end else if (wide) n_seen = 1;
            if (wide) n_lock = 0;
            else if (m_ctick && !m_seen && m_good >= LC - 1) n_lock = 1;
            m_rcnt = n_rcnt; m_sh = n_sh; m_pend = n_pend; m_act = n_act; m_cnt = n_cnt;
            m_w = n_w; m_good = n_good; m_ctick = n_ctick; m_dtick = n_dtick;
            m_up = n_up; m_dn = n_dn; m_seen = n_seen; m_lock = n_lock;
        end
    end

    task automatic chk(input logic actv, input logic expv, input string tag);
        checks++;
        if (actv !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, actv, expv, $time);
        end
    endtask

    task automatic chkv(input logic [4:0] actv, input logic [4:0] expv, input string tag);
        checks++;
        if (actv !== expv) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, actv, expv, $time);
        end
    endtask

    task automatic chki(input int actv, input int expv, input string tag);
        checks++;
        if (actv != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actv, expv, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        logic [4:0] ep;
        #1;
        if (cmp_on && !done) begin
            ep = port_req;
            if (test_route) begin ep[2] = m_ctick; ep[4] = m_dtick; end
            chk(pump_up, m_up && !pump_off, "R6 R7 model pump_up");
            chk(pump_dn, m_dn && !pump_off, "R6 R7 model pump_dn");
            chk(lock_flag, m_lock, "R9 model lock_flag");
            chk(pump_hi, cp_hi, "R8 model pump_hi");
            chk(drive_en, !drive_off, "R8 model drive_en");
            chkv(port_on, ep, "R10 R2 R3 model port_on");
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic shift_word(input int val);
        for (int i = 14; i >= 0; i--) begin
            ratio_sdat = val[i];
            ratio_shift = 1;
            tick();
        end
        ratio_shift = 0;
        ratio_sdat = 0;
    endtask

    task automatic commit();
        ratio_commit = 1;
        tick();
        ratio_commit = 0;
    endtask

    task automatic gap_to_pulse(output int g);
        g = 0;
        do begin tick(); g++; end while (!port_on[4] && g < 100);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(posedge clk);
        cmp_on = 1;
    end

    initial begin
        int cnt, g;
        bit seen0;
        repeat (3) tick();
        // R1 reset state
        chk(lock_flag, 0, "R1 lock_flag in reset");
        chk(pump_up, 0, "R1 pump_up in reset");
        chk(pump_dn, 0, "R1 pump_dn in reset");
        rst_n = 1;
        tick();

        // Align the loop: one oscillator enable first, then both every cycle.
        shift_word(8);
        commit();
        osc_en = 1;
        tick();
        ref_en = 1;
        repeat (REFD * 8) tick();
        chk(lock_flag, 1, "R9 lock acquired with aligned ticks");

        // Ratio 9 drifts one clock per period: lock must drop.
        shift_word(9);
        commit();
        seen0 = 0; cnt = 0;
        repeat (REFD * 12) begin
            tick();
            if (!lock_flag) seen0 = 1;
            if (pump_up || pump_dn) cnt++;
        end
        chk(seen0, 1, "R9 lock lost on wide pulse");
        chk(cnt > 0, 1, "R6 detector pulses on drifting loop");

        // R7 pump silenced
        pump_off = 1;
        cnt = 0;
        repeat (100) begin
            tick();
            if (pump_up || pump_dn) cnt++;
        end
        chki(cnt, 0, "R7 pumps silent with pump_off");
        pump_off = 0;

        // R8 current select and drive enable
        cp_hi = 1; drive_off = 1;
        tick();
        chk(pump_hi, 1, "R8 pump_hi high");
        chk(drive_en, 0, "R8 drive_en off");
        cp_hi = 0; drive_off = 0;
        tick();
        chk(pump_hi, 0, "R8 pump_hi low");
        chk(drive_en, 1, "R8 drive_en on");

        // R10 normal port pass-through
        port_req = 5'b10110;
        tick();
        chkv(port_on, 5'b10110, "R10 ports follow requests");

        // R2 comparison tick rate on port 2
        test_route = 1;
        cnt = 0;
        repeat (80) begin
            tick();
            if (port_on[2]) cnt++;
        end
        chki(cnt, 80 / REFD, "R2 comparison ticks in 80 cycles");

        // R4 shifting without commit leaves the division at 9
        gap_to_pulse(g);
        shift_word(5);
        gap_to_pulse(g);
        gap_to_pulse(g);
        chki(g, 9, "R4 uncommitted word has no effect");
        gap_to_pulse(g);
        chki(g, 9, "R4 uncommitted word has no effect (2)");

        // R5 commit right after a pulse: current cycle keeps 9, next is 5
        ratio_commit = 1;
        tick();
        ratio_commit = 0;
        g = 1;
        while (!port_on[4] && g < 100) begin tick(); g++; end
        chki(g, 9, "R5 running cycle keeps old ratio");
        gap_to_pulse(g);
        chki(g, 5, "R5 new ratio adopted at terminal count");

        // R3 ratio zero divides by one
        shift_word(0);
        commit();
        repeat (20) tick();
        cnt = 0;
        repeat (10) begin
            tick();
            if (port_on[4]) cnt++;
        end
        chki(cnt, 10, "R3 ratio zero divides by one");

        // Irregular enables, model compared every cycle
        test_route = 0;
        shift_word(7);
        commit();
        repeat (2000) begin
            ref_en = ($urandom % 4) != 0;
            osc_en = ($urandom % 2) != 0;
            tick();
        end
        finish_run();
    end
endmodule